// File: doc/BRIEF.md
# System Tick Timer

A periodic down-counting tick timer with four 32-bit registers on a simple register bus. The bus has an address, write data, a read strobe and a write strobe. Software programs a reload value and a control word. While enabled, the counter steps down once per count tick. A count tick is either every core clock or a pulse on an external reference input, and a control bit picks which.

Each time the counter reaches zero it sets a sticky count flag. It can also raise a one-cycle interrupt request. On the following tick it reloads and counts on, so one period is reload+1 ticks. If the reload value is zero, the timer turns itself off after the expiry instead. Reading the control register clears the flag. Writing anything to the current-value register restarts the count from the reload value.

Top module: `tick_timer`

## Requirements
- R1: The registers sit at byte offsets 0x0 (control), 0x4 (reload), 0x8 (current) and 0xC (calibration). Any other offset reads as zero and ignores writes. Read data appears on `bus_rdata` in the cycle after the clock edge that samples `bus_rd`, and holds until the next read.
- R2: In the control register, bit 0 is enable, bit 1 is interrupt enable, bit 2 is tick source (1 = every core clock, 0 = `ref_tick` pulses) and bit 16 is the count flag. A write changes only bits 2:0, and every other bit reads as zero.
- R3: An expiry is the tick on which the counter steps from 1 to 0. It sets the count flag. When interrupt enable is set, `irq` is high for exactly the one cycle after that edge.
- R4: With a nonzero reload, the tick after the counter reaches 0 loads the reload value, so expiries come every reload+1 ticks.
- R5: An expiry with a zero reload value clears the enable bit. A tick while enabled with the counter and reload both at zero also counts as an expiry.
- R6: A read of the control register returns the count flag and then clears it. An expiry on the same edge leaves the flag set.
- R7: A write of any data to the current-value register loads the counter from the reload register and clears the count flag.
- R8: The current-value register reads zero while enable is clear.
- R9: A control write that moves enable from 0 to 1 loads the counter from the reload value on the same edge.
- R10: A control write that changes the tick-source bit loads the counter from the reload value.
- R11: The calibration register always reads 10000, and writes to it have no effect.
- R12: Synchronous reset clears control, reload, counter, flag, `irq` and `bus_rdata`.
- R13: The reload and current-value registers are 24 bits wide. Upper write bits are dropped, and upper read bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Registered read data |
| ref_tick | input | 1 | External reference tick, one pulse per count |
| irq | output | 1 | One-cycle interrupt request |

## Verification
Every result of this block is due one edge after its cause. A strobe or tick sampled at edge N updates the counter, flags and control bits at edge N. `bus_rdata` and `irq` show the result from edge N until edge N+1. A behavioural model in the bench applies the same inputs at each rising edge. At every falling edge, `irq` and `bus_rdata` are compared with the model, so each comparison falls half a cycle after the edge that produced the value. Directed reads check constants at that same falling edge. Interrupt periods are checked by counting pulses over a window of whole periods.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int BUS_AW = 8;
  localparam logic [BUS_AW-1:0] OFS_CTRL   = 8'h00;
  localparam logic [BUS_AW-1:0] OFS_RELOAD = 8'h04;
  localparam logic [BUS_AW-1:0] OFS_CUR    = 8'h08;
  localparam logic [BUS_AW-1:0] OFS_CAL    = 8'h0C;
  localparam int CB_EN   = 0;
  localparam int CB_IE   = 1;
  localparam int CB_SRC  = 2;
  localparam int CB_FLAG = 16;
  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_RELOAD, SEL_CUR, SEL_CAL
  } reg_sel_e;
endpackage

// File: rtl/tick_timer_decode.sv
module tick_timer_decode
  import tick_timer_pkg::*;
(
  input  logic [BUS_AW-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    unique case (addr)
      OFS_CTRL:   sel = SEL_CTRL;
      OFS_RELOAD: sel = SEL_RELOAD;
      OFS_CUR:    sel = SEL_CUR;
      OFS_CAL:    sel = SEL_CAL;
      default:    sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctrl,
  input  logic             wr_reload,
  input  logic             wr_cur,
  input  logic             rd_ctrl,
  input  logic [2:0]       wbits,
  input  logic [CNT_W-1:0] wval,
  input  logic             expire,
  output logic             en,
  output logic             ie,
  output logic             src,
  output logic             flag,
  output logic [CNT_W-1:0] reload,
  output logic             load_req
);
  localparam logic [CNT_W-1:0] ZERO = '0;

  // Restart the count when enable rises or the tick source changes (R9, R10),
  // or on any write to the current value (R7).
  assign load_req = wr_cur | (wr_ctrl & ((wbits[0] & ~en) | (wbits[2] ^ src)));

  always_ff @(posedge clk) begin
    if (rst) begin
      en     <= 1'b0;
      ie     <= 1'b0;
      src    <= 1'b0;
      flag   <= 1'b0;
      reload <= ZERO;
    end else begin
      if (wr_ctrl) begin
        en  <= wbits[0];
        ie  <= wbits[1];
        src <= wbits[2];
      end else if (expire && reload == ZERO) begin
        en <= 1'b0;
      end
      if (expire)                 flag <= 1'b1;
      else if (rd_ctrl || wr_cur) flag <= 1'b0;
      if (wr_reload) reload <= wval;
    end
  end

  AST_ZERO_STOPS: assert property (@(posedge clk) disable iff (rst)
    (expire && reload == ZERO && !wr_ctrl) |=> !en); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_ctrl && !expire) |=> !flag); // R6
  AST_CUR_WR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_cur && !expire) |=> !flag); // R7
endmodule

// File: rtl/tick_timer_count.sv
module tick_timer_count #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             load_req,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic step;
  assign step   = en & tick & ~load_req;
  assign expire = step & ((cnt == ONE) | ((cnt == ZERO) & (reload == ZERO)));

  always_ff @(posedge clk) begin
    if (rst)              cnt <= ZERO;
    else if (load_req)    cnt <= reload;
    else if (step) begin
      if (cnt == ZERO)    cnt <= reload;
      else                cnt <= cnt - ONE;
    end
  end

  AST_LOAD_TAKES_RELOAD: assert property (@(posedge clk) disable iff (rst)
    load_req |=> cnt == $past(reload)); // R9
  AST_WRAP_RELOADS: assert property (@(posedge clk) disable iff (rst)
    (step && cnt == ZERO) |=> cnt == $past(reload)); // R4
  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!en && !load_req) |=> $stable(cnt)); // R8
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int          CNT_W     = 24,
  parameter logic [31:0] CAL_VALUE = 32'd10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic              ref_tick,
  output logic              irq
);
  reg_sel_e         sel;
  logic             wr_ctrl, wr_reload, wr_cur, rd_ctrl;
  logic             en, ie, src, flag, load_req, expire, tick;
  logic [CNT_W-1:0] reload, cnt;
  logic [31:0]      ctrl_word, rd_mux;

  tick_timer_decode u_dec (.addr(bus_addr), .sel(sel));

  assign wr_ctrl   = bus_wr & (sel == SEL_CTRL);
  assign wr_reload = bus_wr & (sel == SEL_RELOAD);
  assign wr_cur    = bus_wr & (sel == SEL_CUR);
  assign rd_ctrl   = bus_rd & (sel == SEL_CTRL);
  assign tick      = src | ref_tick;

  generate
    if (CNT_W < 32) begin : g_narrow
      logic unused_wbits;
      assign unused_wbits = ^{bus_wdata[31:CNT_W], bus_wdata[2:0]};
    end
  endgenerate

  tick_timer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_reload(wr_reload),
    .wr_cur(wr_cur), .rd_ctrl(rd_ctrl), .wbits(bus_wdata[2:0]),
    .wval(bus_wdata[CNT_W-1:0]), .expire(expire), .en(en), .ie(ie),
    .src(src), .flag(flag), .reload(reload), .load_req(load_req)
  );

  tick_timer_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .load_req(load_req),
    .reload(reload), .cnt(cnt), .expire(expire)
  );

  always_comb begin
    ctrl_word          = '0;
    ctrl_word[CB_EN]   = en;
    ctrl_word[CB_IE]   = ie;
    ctrl_word[CB_SRC]  = src;
    ctrl_word[CB_FLAG] = flag;
    unique case (sel)
      SEL_CTRL:   rd_mux = ctrl_word;
      SEL_RELOAD: rd_mux = 32'(reload);
      SEL_CUR:    rd_mux = en ? 32'(cnt) : 32'd0;
      SEL_CAL:    rd_mux = CAL_VALUE;
      default:    rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= 32'd0;
      irq       <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      irq <= expire & ie;
    end
  end

  AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag); // R3
  AST_IRQ_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    !(expire && ie) |=> !irq); // R3
endmodule

// File: tb/tick_timer_test.sv
`timescale 1ns/100ps
module tick_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  b_addr = '0;
  logic [31:0] b_wd = '0;
  logic        b_wr = 1'b0, b_rd = 1'b0, ref_tick = 1'b0;
  logic [31:0] rdata;
  logic        irq;

  always #2.5 clk = ~clk;

  tick_timer uut (
    .clk(clk), .rst(rst), .bus_addr(b_addr), .bus_wdata(b_wd),
    .bus_wr(b_wr), .bus_rd(b_rd), .bus_rdata(rdata),
    .ref_tick(ref_tick), .irq(irq)
  );

  int vectors = 0, errors = 0, irq_seen = 0, cycles = 0;
  string phase = "R12";

  // Behavioural model of the register behaviour
  bit m_en, m_ie, m_src, m_flag, m_irq;
  int unsigned m_rel, m_cnt, m_rd;

  always @(posedge clk) begin
    bit tk, wc, wcur, rc, ld, ex;
    int unsigned rv;
    if (rst) begin
      m_en = 0; m_ie = 0; m_src = 0; m_flag = 0; m_irq = 0;
      m_rel = 0; m_cnt = 0; m_rd = 0;
    end else begin
      tk   = m_src || ref_tick;
      wc   = b_wr && b_addr == 8'h00;
      wcur = b_wr && b_addr == 8'h08;
      rc   = b_rd && b_addr == 8'h00;
      ld   = wcur || (wc && ((b_wd[0] && !m_en) || (b_wd[2] != m_src)));
      ex   = m_en && tk && !ld && (m_cnt == 1 || (m_cnt == 0 && m_rel == 0));
      if (b_rd) begin
        case (b_addr)
          8'h00: rv = {15'd0, m_flag, 13'd0, m_src, m_ie, m_en};
          8'h04: rv = m_rel;
          8'h08: rv = m_en ? m_cnt : 0;
          8'h0C: rv = 10000;
          default: rv = 0;
        endcase
        m_rd = rv;
      end
      m_irq = ex && m_ie;
      if (ld) m_cnt = m_rel;
      else if (m_en && tk) m_cnt = (m_cnt == 0) ? m_rel : m_cnt - 1;
      if (ex) m_flag = 1; else if (rc || wcur) m_flag = 0;
      if (wc) begin m_en = b_wd[0]; m_ie = b_wd[1]; m_src = b_wd[2]; end
      else if (ex && m_rel == 0) m_en = 0;
      if (b_wr && b_addr == 8'h04) m_rel = b_wd & 32'h00FF_FFFF;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      cycles++;
      if (irq === 1'b1) irq_seen++;
      check({phase, " irq"}, {31'd0, irq}, {31'd0, m_irq});
      check({phase, " rdata"}, rdata, m_rd);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    b_addr = a; b_wd = d; b_wr = 1'b1;
    @(posedge clk); #1;
    b_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    b_addr = a; b_rd = 1'b1;
    @(posedge clk); #1;
    b_rd = 1'b0;
    @(negedge clk);
    check(tag, rdata, exp);
    @(posedge clk); #1;
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    // R12 reset state, R8 current reads zero when disabled
    phase = "R12";
    rd_chk(8'h00, 32'h0, "R12 ctrl after reset");
    rd_chk(8'h04, 32'h0, "R12 reload after reset");
    rd_chk(8'h08, 32'h0, "R8 current while disabled");
    // R11 calibration, R1 unmapped offset
    phase = "R11";
    rd_chk(8'h0C, 32'd10000, "R11 calibration");
    wr(8'h0C, 32'h5);
    rd_chk(8'h0C, 32'd10000, "R11 calibration after write");
    phase = "R1";
    wr(8'h10, 32'h7);
    rd_chk(8'h10, 32'h0, "R1 unmapped read");
    rd_chk(8'h00, 32'h0, "R1 unmapped write ignored");
    // R13 width, R2 write mask, R9 enable loads
    phase = "R13";
    wr(8'h04, 32'hFFFF_FFFF);
    rd_chk(8'h04, 32'h00FF_FFFF, "R13 reload width");
    phase = "R2";
    wr(8'h00, 32'hFFFF_FFFB);
    rd_chk(8'h00, 32'h3, "R2 writable bits");
    rd_chk(8'h08, 32'h00FF_FFFF, "R9 enable loads reload");
    wr(8'h00, 32'h0);
    // R4 period reload+1
    phase = "R4";
    wr(8'h04, 32'd4);
    wr(8'h00, 32'h7);
    irq_seen = 0;
    idle(50);
    check("R4 irq count over 50 cycles", irq_seen, 10);
    // R6 flag read-clear
    phase = "R6";
    wr(8'h00, 32'h0);
    rd_chk(8'h00, 32'h0001_0000, "R6 flag visible");
    rd_chk(8'h00, 32'h0, "R6 flag cleared by read");
    // R7 current write reloads and clears
    phase = "R7";
    wr(8'h04, 32'd9);
    wr(8'h00, 32'h5);
    idle(12);
    wr(8'h08, 32'd123);
    rd_chk(8'h00, 32'h5, "R7 flag cleared by current write");
    rd_chk(8'h08, 32'd7, "R7 counter reloaded");
    // R5 zero reload stops
    phase = "R5";
    wr(8'h00, 32'h0);
    wr(8'h04, 32'd3);
    wr(8'h00, 32'h7);
    wr(8'h04, 32'd0);
    idle(10);
    rd_chk(8'h00, 32'h0001_0006, "R5 zero reload clears enable");
    rd_chk(8'h08, 32'h0, "R8 current after stop");
    wr(8'h00, 32'h7);
    idle(3);
    rd_chk(8'h00, 32'h0001_0006, "R5 enable with zero reload expires once");
    // R10 source change reloads
    phase = "R10";
    ref_tick = 1'b0;
    wr(8'h04, 32'd200);
    wr(8'h00, 32'h5);
    idle(20);
    wr(8'h00, 32'h1);
    rd_chk(8'h08, 32'd200, "R10 source change reloads");
    // R3 random reference ticks
    phase = "R3";
    wr(8'h04, 32'd3);
    wr(8'h00, 32'h3);
    irq_seen = 0;
    for (int i = 0; i < 400; i++) begin
      ref_tick = 1'($urandom_range(0, 1));
      b_addr = (i % 3 == 0) ? 8'h00 : 8'h08;
      b_rd = (i % 5 == 0);
      @(posedge clk); #1;
    end
    b_rd = 1'b0; ref_tick = 1'b0;
    idle(2);
    check("R3 interrupts seen with reference ticks", {31'd0, irq_seen > 0}, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(100000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule